// File: doc/BRIEF.md
# Programming Command Scan Register

This block is a boundary-scan data register that carries programming commands from a test host to a nonvolatile memory controller. It sits beside an existing test-access-port controller. From that controller it takes one strobe for each of four states: capture, shift, update and run-idle. It also takes an instruction-select line and the serial input. It drives the serial output.

The register is 15 bits long and works in three steps. A capture loads the result that the memory controller reported for the command executed before. Shifting then moves that result out while the next command moves in. An update hands the new command to the controller and marks it as applied. The command does not run at update. It runs only when the scan state machine next passes through run-idle. There the block issues a single execute pulse, whatever the number of idle cycles.

The controller's result port may be narrower than the register. In that case the missing upper bits read as zero.

Top module: `pgm_cmd_dr`

## Requirements
- R1: The register holds W = 15 bits. After a capture and W shift cycles, all W bits of the captured value have appeared on `tdo`.
- R2: A capture edge with `sel` high loads the result word into the register. On the following cycle, `tdo` shows bit 0 of that result.
- R3: Each shift edge with `sel` high moves the register one place toward bit 0, and `tdi` enters at bit W-1. Before a shift edge, `tdo` shows the current bit 0. Results therefore leave least significant bit first, and commands enter least significant bit first.
- R4: An update edge with `sel` high copies the register to `cmd_word`. It also raises `cmd_apply` for exactly the one cycle after that edge. At all other times `cmd_word` keeps its value.
- R5: The first run-idle edge after an update raises `exec_pulse` for exactly one cycle. Further idle edges produce no further pulse.
- R6: `exec_pulse` never rises unless an update came before it and has not yet been executed. This covers idling straight after reset, and a capture or shift sequence that ends without an update.
- R7: While `sel` is low, every strobe is ignored and `tdo` is 0. The register, `cmd_word` and the pending-execute state all keep their values.
- R8: While `trst_n` is low, `tdo` is 0 and the register, `cmd_word`, `cmd_apply` and `exec_pulse` are all zero.
- R9: When RES_W < W, register bits W-1 down to RES_W are loaded with 0 at capture, so they shift out as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; every state change happens on its rising edge |
| trst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | High while the instruction register selects this data register |
| st_capture | input | 1 | Scan controller is in the capture state |
| st_shift | input | 1 | Scan controller is in the shift state |
| st_update | input | 1 | Scan controller is in the update state |
| st_idle | input | 1 | Scan controller is in run-test/idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the register (0 when not selected) |
| cmd_word | output | W | Command presented to the memory controller |
| cmd_apply | output | 1 | One-cycle strobe following an update |
| exec_pulse | output | 1 | One-cycle execute clock for the applied command |
| result_in | input | RES_W | Result of the last executed command |

## Verification
The bench keeps W at its default of 15 and builds the block with RES_W = 12. With those values, the three upper result bits take the zero-fill path of R9 on every capture. A bench responder returns a 12-bit function of each executed command. This lets each capture be compared against the command that ran one round earlier. Deselected scan sequences are placed between selected ones. Because the bench then shifts without a fresh capture, the bits that come out show whether the register and the pending-execute state survived unchanged.

// File: rtl/pgm_cmd_dr_pkg.sv
package pgm_cmd_dr_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CAPTURE = 3'd1,
        OP_SHIFT   = 3'd2,
        OP_UPDATE  = 3'd3,
        OP_IDLE    = 3'd4
    } scan_op_e;

    // Strobes are expected to be exclusive; a fixed priority keeps the
    // decode defined if more than one is high.
    function automatic scan_op_e decode_op(
        input logic sel,
        input logic cap,
        input logic sh,
        input logic upd,
        input logic idle
    );
        scan_op_e op;
        op = OP_NONE;
        if (sel) begin
            if (cap)       op = OP_CAPTURE;
            else if (sh)   op = OP_SHIFT;
            else if (upd)  op = OP_UPDATE;
            else if (idle) op = OP_IDLE;
        end
        return op;
    endfunction

endpackage

// File: rtl/pcd_shifter.sv
module pcd_shifter
    import pgm_cmd_dr_pkg::*;
#(
    parameter int W     = 15,
    parameter int RES_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_op_e         op,
    input  logic             ser_in,
    input  logic [RES_W-1:0] result,
    output logic [W-1:0]     chain
);

    typedef struct packed {
        logic [W-1:0] bits;
    } shf_state_t;

    shf_state_t   st_d, st_q;
    logic [W-1:0] result_ext;

    always_comb begin
        result_ext              = '0;
        result_ext[RES_W-1:0]   = result;
    end

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CAPTURE: st_d.bits = result_ext;
            OP_SHIFT:   st_d.bits = {ser_in, st_q.bits[W-1:1]};
            default:    st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain = st_q.bits;

endmodule

// File: rtl/pcd_cmd_hold.sv
module pcd_cmd_hold
    import pgm_cmd_dr_pkg::*;
#(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  scan_op_e     op,
    input  logic [W-1:0] chain,
    output logic [W-1:0] cmd,
    output logic         apply
);

    typedef struct packed {
        logic [W-1:0] cmd;
        logic         apply;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.apply = 1'b0;
        if (op == OP_UPDATE) begin
            st_d.cmd   = chain;
            st_d.apply = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd   = st_q.cmd;
    assign apply = st_q.apply;

endmodule

// File: rtl/pcd_exec_gen.sv
module pcd_exec_gen
    import pgm_cmd_dr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  scan_op_e op,
    output logic     fire
);

    typedef struct packed {
        logic armed;
        logic fire;
    } exec_state_t;

    exec_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        case (op)
            OP_UPDATE: st_d.armed = 1'b1;
            OP_IDLE: begin
                st_d.fire  = st_q.armed;
                st_d.armed = 1'b0;
            end
            default: st_d.armed = st_q.armed;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = st_q.fire;

endmodule

// File: rtl/pgm_cmd_dr.sv
module pgm_cmd_dr
    import pgm_cmd_dr_pkg::*;
#(
    parameter int W     = 15,
    parameter int RES_W = 15
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel,
    input  logic             st_capture,
    input  logic             st_shift,
    input  logic             st_update,
    input  logic             st_idle,
    input  logic             tdi,
    output logic             tdo,
    output logic [W-1:0]     cmd_word,
    output logic             cmd_apply,
    output logic             exec_pulse,
    input  logic [RES_W-1:0] result_in
);

    scan_op_e     op;
    logic [W-1:0] chain;

    assign op = decode_op(sel, st_capture, st_shift, st_update, st_idle);

    pcd_shifter #(.W(W), .RES_W(RES_W)) u_shift (
        .clk    (tck),
        .rst_n  (trst_n),
        .op     (op),
        .ser_in (tdi),
        .result (result_in),
        .chain  (chain)
    );

    pcd_cmd_hold #(.W(W)) u_hold (
        .clk   (tck),
        .rst_n (trst_n),
        .op    (op),
        .chain (chain),
        .cmd   (cmd_word),
        .apply (cmd_apply)
    );

    pcd_exec_gen u_exec (
        .clk   (tck),
        .rst_n (trst_n),
        .op    (op),
        .fire  (exec_pulse)
    );

    assign tdo = sel ? chain[0] : 1'b0;

endmodule

// File: rtl/pgm_cmd_dr_chk.sv
module pgm_cmd_dr_chk #(
    parameter int W = 15
) (
    input logic         tck,
    input logic         trst_n,
    input logic         sel,
    input logic         st_capture,
    input logic         st_update,
    input logic         st_idle,
    input logic         tdo,
    input logic [W-1:0] cmd_word,
    input logic         cmd_apply,
    input logic         exec_pulse,
    input logic         res_lsb
);

    p_tdo_quiet_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |-> (tdo == 1'b0));

    p_capture_lsb_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && $past(sel && st_capture)) |-> (tdo == $past(res_lsb)));

    p_apply_origin_r4: assert property (@(posedge tck) disable iff (!trst_n)
        cmd_apply |-> $past(sel && st_update));

    p_cmd_held_r4: assert property (@(posedge tck) disable iff (!trst_n)
        !cmd_apply |-> $stable(cmd_word));

    p_exec_single_r5: assert property (@(posedge tck) disable iff (!trst_n)
        exec_pulse |=> !exec_pulse);

    p_exec_origin_r6: assert property (@(posedge tck) disable iff (!trst_n)
        exec_pulse |-> $past(sel && st_idle));

endmodule

bind pgm_cmd_dr pgm_cmd_dr_chk #(.W(W)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .sel        (sel),
    .st_capture (st_capture),
    .st_update  (st_update),
    .st_idle    (st_idle),
    .tdo        (tdo),
    .cmd_word   (cmd_word),
    .cmd_apply  (cmd_apply),
    .exec_pulse (exec_pulse),
    .res_lsb    (result_in[0])
);

// File: tb/pgm_cmd_dr_test.sv
module pgm_cmd_dr_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 15;
    localparam int RES_W      = 12;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             sel = 1'b0;
    logic             st_capture = 1'b0;
    logic             st_shift = 1'b0;
    logic             st_update = 1'b0;
    logic             st_idle = 1'b0;
    logic             tdi = 1'b0;
    logic             tdo;
    logic [W-1:0]     cmd_word;
    logic             cmd_apply;
    logic             exec_pulse;
    logic [RES_W-1:0] result_in = '0;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];

    always #(CLK_PERIOD/2) tck = ~tck;

    pgm_cmd_dr #(.W(W), .RES_W(RES_W)) uut (
        .tck(tck), .trst_n(trst_n), .sel(sel),
        .st_capture(st_capture), .st_shift(st_shift),
        .st_update(st_update), .st_idle(st_idle),
        .tdi(tdi), .tdo(tdo), .cmd_word(cmd_word),
        .cmd_apply(cmd_apply), .exec_pulse(exec_pulse),
        .result_in(result_in)
    );

    function automatic logic [RES_W-1:0] respond(input logic [W-1:0] c);
        return c[RES_W-1:0] ^ 12'hC35;
    endfunction

    // Responder: memory controller produces a result when told to execute.
    always @(negedge tck) if (exec_pulse) result_in = respond(cmd_word);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every selected shift cycle's tdo against the scoreboard.
    always @(negedge tck) begin
        #1;
        if (trst_n && sel && st_shift) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 actual=%0b expected=<none>", tdo);
            end else begin
                bit e;
                e = exp_q.pop_front();
                if (tdo !== e) begin
                    fails++;
                    $display("FAIL R1/R3 tdo actual=%0b expected=%0b", tdo, e);
                end
            end
        end
    end

    task automatic step(input logic s, input logic c, input logic sh,
                        input logic u, input logic i, input logic d);
        @(negedge tck);
        sel = s; st_capture = c; st_shift = sh; st_update = u; st_idle = i; tdi = d;
        #2;
    endtask

    task automatic push_word(input logic [W-1:0] v);
        for (int k = 0; k < W; k++) exp_q.push_back(v[k]);
    endtask

    task automatic scan(input logic [W-1:0] cmd, input logic [W-1:0] exp_res);
        step(1, 1, 0, 0, 0, 0);
        push_word(exp_res);
        for (int k = 0; k < W; k++) step(1, 0, 1, 0, 0, cmd[k]);
        step(1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R4 apply after update", cmd_apply, 1);
        check("R4 cmd_word", cmd_word, cmd);
        check("R5 no exec before idle", exec_pulse, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R5 exec on first idle", exec_pulse, 1);
        check("R4 apply one cycle", cmd_apply, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R5 no second exec", exec_pulse, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R5 still no exec", exec_pulse, 0);
    endtask

    localparam logic [W-1:0] CMD_A = 15'h2A3C;
    localparam logic [W-1:0] CMD_B = 15'h7F01;
    localparam logic [W-1:0] CMD_C = 15'h1E5B;

    initial begin
        logic [W-1:0] ext;
        repeat (3) @(negedge tck);
        check("R8 reset tdo", tdo, 0);
        check("R8 reset cmd", cmd_word, 0);
        check("R8 reset exec", exec_pulse, 0);
        trst_n = 1'b1;
        step(1, 0, 0, 0, 0, 0);
        check("R8 tdo after reset", tdo, 0);
        check("R8 apply after reset", cmd_apply, 0);

        // R6: idle with nothing applied.
        for (int k = 0; k < 3; k++) begin
            step(1, 0, 0, 0, 1, 0);
            check("R6 idle without update", exec_pulse, 0);
        end

        // R1 R2 R3 R4 R5: first round captures the reset result.
        scan(CMD_A, '0);
        // R9: captured result is 12 bits wide, upper 3 bits zero.
        ext = '0; ext[RES_W-1:0] = respond(CMD_A);
        scan(CMD_B, ext);

        // R7: deselected strobes are ignored.
        step(0, 1, 0, 0, 0, 0);
        check("R7 tdo deselected", tdo, 0);
        for (int k = 0; k < W; k++) begin
            step(0, 0, 1, 0, 0, 1'b1);
            check("R7 tdo deselected shift", tdo, 0);
        end
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        check("R7 no apply deselected", cmd_apply, 0);
        step(0, 0, 0, 0, 1, 0);
        check("R7 no exec deselected", exec_pulse, 0);
        check("R7 cmd held", cmd_word, CMD_B);

        // R7: register kept CMD_B; shift it out without capture.
        push_word(CMD_B);
        for (int k = 0; k < W; k++) step(1, 0, 1, 0, 0, CMD_C[k]);
        step(1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R4 cmd after reselect", cmd_word, CMD_C);
        step(1, 0, 0, 0, 1, 0);
        check("R5 exec after reselect", exec_pulse, 1);

        // R6: capture and partial shift, no update, then idle.
        step(1, 1, 0, 0, 0, 0);
        ext = '0; ext[RES_W-1:0] = respond(CMD_C);
        for (int k = 0; k < 5; k++) exp_q.push_back(ext[k]);
        for (int k = 0; k < 5; k++) step(1, 0, 1, 0, 0, 1'b0);
        step(1, 0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R6 no exec without update", exec_pulse, 0);
        step(1, 0, 0, 0, 1, 0);
        check("R6 no exec later", exec_pulse, 0);
        check("R6 cmd unchanged", cmd_word, CMD_C);

        check("R1 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule